// File: doc/BRIEF.md
# Reaction Timer with Two-Digit Decimal Readout

This block measures how long a person takes to respond to a light, in hundredths of a second. A free-running binary prescaler divides the system clock by a power of two to make a one-cycle counting tick; with the default 10-bit prescaler and a 102.4 kHz system clock the tick rate is 100 Hz. A single run flop drives the LED and gates the tick into a cascade of decimal digit counters.

A one-cycle pulse on `start_w` lights the LED and starts counting. The person presses a push button, which pulls the active-low `btn_n` input to 0. That press clears the run flop and freezes the count, and the count stays on the display. Both digits are decoded to active-high seven-segment patterns. Debouncing and any random pre-start delay belong to logic outside this block.

Top module: `reaction_timer`

## Requirements
- R1: The prescaler raises an internal tick for exactly one clock in every 2^DIV_BITS clocks, starting 2^DIV_BITS clocks after reset releases. While the LED is on, each tick adds one to the displayed count.
- R2: While `rst` is high, `led`, both digits and the prescaler are held at zero.
- R3: If `start_w` is 1 and `btn_n` is 1 at a clock edge, `led` is 1 after that edge. It stays 1 after `start_w` returns to 0, until the button is pressed or reset is applied.
- R4: While `led` is 0, the digits do not change.
- R5: If `btn_n` is 0 at a clock edge, `led` is 0 after that edge, and the count reached so far stays on the digit outputs.
- R6: If `btn_n` is 0 and `start_w` is 1 at the same edge, the press wins and `led` ends up 0.
- R7: `digit_lo` counts 0 to 9. On a tick at 9 it returns to 0 and `digit_hi` advances by one. A tick at 99 gives 00.
- R8: Each seven-segment output is active-high with bit 6 = segment a down to bit 0 = segment g. The patterns for 0 to 9 are 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F, 7B (hex).
- R9: A new `start_w` pulse after a stop resumes counting from the held value. It does not clear the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| start_w | input | 1 | Start pulse; lights the LED and enables counting |
| btn_n | input | 1 | Push button, 1 when released, 0 when pressed |
| led | output | 1 | Run state and LED drive |
| digit_lo | output | 4 | Hundredths digit (BCD) |
| digit_hi | output | 4 | Tenths digit (BCD) |
| seg_lo | output | 7 | Segment pattern for `digit_lo`, bit 6 = a |
| seg_hi | output | 7 | Segment pattern for `digit_hi`, bit 6 = a |

## Verification
Some properties are checked by assertions on every cycle:
- the tick is only ever one cycle wide;
- a start sets the run flop and a press clears it;
- a digit never leaves 0 to 9, holds when it is not enabled, and wraps from 9 to 0;
- the whole display holds while the LED is off.

Other behaviour only the bench can show, by comparing every cycle against a behavioural model of elapsed ticks:
- the tick spacing;
- that the count on display equals the number of ticks seen while running;
- resuming after a stop;
- the 99 to 00 rollover;
- the exact segment patterns.

// File: rtl/rt_pkg.sv
package rt_pkg;

  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned SEG_W   = 7;

  // Next value of one decimal digit; 9 folds back to 0.
  function automatic logic [DIGIT_W-1:0] bcd_next(input logic [DIGIT_W-1:0] d);
    if (d >= 4'd9) return '0;
    return d + 4'd1;
  endfunction

  // Active-high segments, bit 6 = a ... bit 0 = g.
  function automatic logic [SEG_W-1:0] bcd_to_seg(input logic [DIGIT_W-1:0] d);
    logic [SEG_W-1:0] s;
    case (d)
      4'd0:    s = 7'b1111110;
      4'd1:    s = 7'b0110000;
      4'd2:    s = 7'b1101101;
      4'd3:    s = 7'b1111001;
      4'd4:    s = 7'b0110011;
      4'd5:    s = 7'b1011011;
      4'd6:    s = 7'b1011111;
      4'd7:    s = 7'b1110000;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1111011;
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rt_tick_div.sv
module rt_tick_div #(
  parameter int unsigned DIV_BITS = 10
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  logic [DIV_BITS-1:0] cnt_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign tick = &cnt_q;

  // R1
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R1
  tick_from_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == '0));

endmodule

// File: rtl/rt_run_state.sv
module rt_run_state (
  input  logic clk,
  input  logic rst,
  input  logic start_w,
  input  logic btn_n,
  output logic run
);

  logic press;
  assign press = ~btn_n;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          run <= 1'b0;
    else if (press)   run <= 1'b0;
    else if (start_w) run <= 1'b1;
  end

  // R3
  run_set_chk: assert property (@(posedge clk) disable iff (rst)
    (start_w && btn_n) |=> run);

  // R5 R6
  run_stop_chk: assert property (@(posedge clk) disable iff (rst)
    press |=> !run);

  // R3
  run_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (run && btn_n) |=> run);

endmodule

// File: rtl/rt_bcd_digit.sv
module rt_bcd_digit
  import rt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  output logic [DIGIT_W-1:0] val,
  output logic               carry
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)     val <= '0;
    else if (en) val <= bcd_next(val);
  end

  assign carry = en && (val == 4'd9);

  // R7
  digit_range_chk: assert property (@(posedge clk) disable iff (rst)
    val <= 4'd9);

  // R7
  digit_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    carry |=> (val == '0));

  // R4
  digit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(val));

endmodule

// File: rtl/reaction_timer.sv
module reaction_timer
  import rt_pkg::*;
#(
  parameter int unsigned DIV_BITS = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_w,
  input  logic               btn_n,
  output logic               led,
  output logic [DIGIT_W-1:0] digit_lo,
  output logic [DIGIT_W-1:0] digit_hi,
  output logic [SEG_W-1:0]   seg_lo,
  output logic [SEG_W-1:0]   seg_hi
);

  localparam int unsigned NUM_DIGITS = 2;

  logic                     tick;
  logic                     run;
  logic [NUM_DIGITS:0]      en_chain;
  logic [DIGIT_W-1:0]       dig [NUM_DIGITS];
  logic [SEG_W-1:0]         seg [NUM_DIGITS];

  rt_tick_div #(.DIV_BITS(DIV_BITS)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  rt_run_state u_state (
    .clk     (clk),
    .rst     (rst),
    .start_w (start_w),
    .btn_n   (btn_n),
    .run     (run)
  );

  assign en_chain[0] = tick & run;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    rt_bcd_digit u_digit (
      .clk   (clk),
      .rst   (rst),
      .en    (en_chain[i]),
      .val   (dig[i]),
      .carry (en_chain[i+1])
    );
    assign seg[i] = bcd_to_seg(dig[i]);
  end

  assign led      = run;
  assign digit_lo = dig[0];
  assign digit_hi = dig[1];
  assign seg_lo   = seg[0];
  assign seg_hi   = seg[1];

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !led |=> ($stable(digit_lo) && $stable(digit_hi)));

  // R7
  full_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    en_chain[NUM_DIGITS] |=> (digit_lo == '0 && digit_hi == '0));

  // R1
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && led && digit_lo != 4'd9) |=> (digit_lo == $past(digit_lo) + 4'd1));

endmodule

// File: tb/reaction_timer_tb.sv
module reaction_timer_tb;

  localparam int unsigned DIV_BITS = 4;
  localparam int DIVN = 1 << DIV_BITS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_w = 1'b0;
  logic       btn_n = 1'b1;
  logic       led;
  logic [3:0] digit_lo, digit_hi;
  logic [6:0] seg_lo, seg_hi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  int m_div = 0;
  int m_count = 0;
  bit m_run = 0;

  logic [6:0] SEGS [10] = '{7'h7E, 7'h30, 7'h6D, 7'h79, 7'h33,
                            7'h5B, 7'h5F, 7'h70, 7'h7F, 7'h7B};

  reaction_timer #(.DIV_BITS(DIV_BITS)) u_dut (
    .clk(clk), .rst(rst), .start_w(start_w), .btn_n(btn_n),
    .led(led), .digit_lo(digit_lo), .digit_hi(digit_hi),
    .seg_lo(seg_lo), .seg_hi(seg_hi)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Model: elapsed ticks while running, modulo 100
  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_count = 0; m_run = 0;
    end else begin
      if (m_div == DIVN - 1 && m_run) m_count = (m_count + 1) % 100;
      if (!btn_n)       m_run = 0;
      else if (start_w) m_run = 1;
      m_div = (m_div + 1) % DIVN;
    end
  end

  // Per-cycle comparison
  always @(negedge clk) begin
    if (!done) begin
      chk(led == m_run, "R3/R5 led", led, m_run);
      chk(digit_lo == m_count % 10, "R1 digit_lo", digit_lo, m_count % 10);
      chk(digit_hi == m_count / 10, "R7 digit_hi", digit_hi, m_count / 10);
      chk(seg_lo == SEGS[m_count % 10], "R8 seg_lo", seg_lo, SEGS[m_count % 10]);
      chk(seg_hi == SEGS[m_count / 10], "R8 seg_hi", seg_hi, SEGS[m_count / 10]);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_w = 1'b1; cyc(1); start_w = 1'b0;
  endtask

  task automatic press();
    btn_n = 1'b0; cyc(1); btn_n = 1'b1;
  endtask

  function automatic int shown();
    return digit_hi * 10 + digit_lo;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int held;
    cyc(3);
    // R2 reset state
    chk(led == 0 && shown() == 0, "R2 reset", shown(), 0);
    rst = 1'b0;
    cyc(40);
    // R4 idle does not count
    chk(shown() == 0 && led == 0, "R4 idle", shown(), 0);

    // R3 start pulse
    pulse_start();
    chk(led == 1, "R3 led on", led, 1);
    cyc(5);
    chk(led == 1, "R3 led held", led, 1);
    cyc(DIVN * 7);
    // R1 count tracks elapsed ticks
    chk(shown() == m_count && m_count >= 6, "R1 elapsed", shown(), m_count);

    // R5 stop on press
    press();
    held = shown();
    chk(led == 0, "R5 led off", led, 0);
    cyc(DIVN * 5);
    chk(shown() == held, "R5 frozen", shown(), held);

    // R9 resume from held value
    pulse_start();
    cyc(DIVN * 3);
    chk(shown() == held + 3, "R9 resume", shown(), held + 3);

    // R2 reset mid-run
    rst = 1'b1; cyc(2);
    chk(led == 0 && shown() == 0, "R2 reset mid-run", shown(), 0);
    rst = 1'b0; cyc(3);

    // R6 press beats start
    start_w = 1'b1; btn_n = 1'b0; cyc(1);
    start_w = 1'b0; btn_n = 1'b1;
    chk(led == 0, "R6 press wins", led, 0);
    cyc(DIVN * 2);
    chk(shown() == 0, "R6 no count", shown(), 0);

    // R7 carry and rollover
    pulse_start();
    while (m_count != 10) cyc(1);
    chk(digit_hi == 1 && digit_lo == 0, "R7 carry to 10", shown(), 10);
    chk(seg_hi == 7'h30 && seg_lo == 7'h7E, "R8 seg 10", {seg_hi, seg_lo}, {7'h30, 7'h7E});
    while (m_count != 99) cyc(1);
    chk(shown() == 99, "R7 at 99", shown(), 99);
    chk(seg_lo == 7'h7B, "R8 seg 9", seg_lo, 7'h7B);
    while (m_count != 0) cyc(1);
    chk(shown() == 0 && led == 1, "R7 wrap to 00", shown(), 0);
    cyc(DIVN * 2);
    chk(shown() == 2, "R7 after wrap", shown(), 2);
    press();
    cyc(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule